// File: doc/BRIEF.md
# PWM Compare and Action-Qualifier Stage

This block sits behind a time-base counter. It turns the running count into two pulse-width-modulated outputs, A and B. It holds one 16-bit compare value per output. Each compare value can be written straight into its active copy, or staged in a shadow copy that moves into the active copy at a selectable point in the count cycle: the counter reaching zero, the counter reaching its period, either of these, or never.

Each clock cycle is one counter tick. The stage detects three events on each tick:
- the zero strobe from the counter;
- a match of the up-counting value against active compare A;
- a match of the up-counting value against active compare B.

Each output has its own action word. The action word gives every event a 2-bit code that leaves the output alone, drives it low, drives it high, or toggles it. A per-channel continuous force holds an output low or high for as long as the force is set, whatever the events ask for.

Typical use: drive the output high on zero and low on a compare match. The high time in ticks then equals the compare value. Swapping those two actions gives the inverted waveform.

Top module: `pwm_aq_stage`

## Requirements
- R1: While reset is asserted, both outputs are low and both active compare values read zero. Reset assertion takes effect without waiting for a clock edge.
- R2: With shadowing off for a compare (shadow enable 0), a write shows on that compare's active value one clock after the write cycle.
- R3: With shadowing on (shadow enable 1), a write leaves the active value unchanged. The staged value moves into the active value on the clock after the selected load moment. Load-select 0 loads on the zero strobe, 1 on the period strobe, and 2 on either strobe.
- R4: With shadowing on and load-select 3, the active value never changes, whatever writes and strobes arrive.
- R5: A compare event fires only on a tick where the up-direction input is 1 and the count equals that compare's active value. In each output's 12-bit action word, the zero event uses bits 1:0, the compare-A event uses bits 5:4 and the compare-B event uses bits 9:8. Compare A drives only the bits 5:4 field and compare B drives only the bits 9:8 field.
- R6: Action code 0 leaves the output unchanged, 1 drives it low, 2 drives it high, and 3 inverts it. The output is registered and changes on the clock edge that samples the event. It holds its value on ticks with no event that carries a nonzero code.
- R7: When several events fire on the same tick, the one with the highest rank that has a nonzero code decides. Compare B ranks above compare A, and compare A ranks above zero.
- R8: The 4-bit force word uses bits 1:0 for output A and bits 3:2 for output B. Code 1 holds the output low and code 2 holds it high, starting one clock after the force is applied and lasting as long as it stays set. Codes 0 and 3 leave the action logic in control.
- R9: With action code 2 on zero and code 1 on the output's own compare, and a counter running 0 to P, the output is high for exactly C ticks of every P+1. C is the compare value, capped at P+1, so a compare of 0 gives a permanently low output.
- R10: With action code 1 on zero and code 2 on the output's own compare, the output is low for C ticks and high for the rest of each period. A compare of 0 gives a permanently high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | 16 | Current time-base count |
| cnt_zero | input | 1 | Count is zero on this tick |
| cnt_prd | input | 1 | Count equals the period on this tick |
| cnt_up | input | 1 | Counter is counting up |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_wdata | input | 16 | Write data for compare A |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_wdata | input | 16 | Write data for compare B |
| cmpa_shadow_en | input | 1 | 1: compare A writes are staged |
| cmpa_load_sel | input | 2 | Compare A load moment (0 zero, 1 period, 2 either, 3 never) |
| cmpb_shadow_en | input | 1 | 1: compare B writes are staged |
| cmpb_load_sel | input | 2 | Compare B load moment, same coding |
| act_a_cfg | input | 12 | Action word for output A |
| act_b_cfg | input | 12 | Action word for output B |
| force_cfg | input | 4 | Continuous force, A in bits 1:0, B in bits 3:2 |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cmpa_active | output | 16 | Active compare A value |
| cmpb_active | output | 16 | Active compare B value |

## Verification
A wrong active compare value shows on the compare readback port one clock after the write or load that caused it. Over a full period it also shows as a high time that differs from the compare value. A bad event decode or a bad priority choice shows on the output at the very next clock edge. The error then persists until some other event overrides it, so a single mis-resolved tick is seen at once. A force that fails to override shows one clock after the force is set, and stays visible for as long as the force stays set.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  // action code per event
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } aq_act_e;

  // shadow load moment
  typedef enum logic [1:0] {
    LD_ZERO   = 2'd0,
    LD_PRD    = 2'd1,
    LD_EITHER = 2'd2,
    LD_FREEZE = 2'd3
  } ld_sel_e;

  // continuous force code
  typedef enum logic [1:0] {
    FRC_OFF  = 2'd0,
    FRC_LOW  = 2'd1,
    FRC_HIGH = 2'd2,
    FRC_RSVD = 2'd3
  } frc_e;

  localparam int NUM_CMP      = 2;
  localparam int NUM_EV       = NUM_CMP + 1;   // zero, cmp A, cmp B (rising rank)
  localparam int FIELD_STRIDE = 4;             // event i field at bits 4i+1:4i
  localparam int ACT_W        = 12;
  localparam int FRC_W        = 2 * NUM_CMP;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  function automatic logic [ACT_W-1:0] used_act_mask();
    logic [ACT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      m[i*FIELD_STRIDE +: 2] = 2'b11;
    end
    return m;
  endfunction

  function automatic logic apply_action(aq_act_e code, logic cur);
    logic res;
    case (code)
      ACT_LOW:    res = 1'b0;
      ACT_HIGH:   res = 1'b1;
      ACT_TOGGLE: res = ~cur;
      default:    res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pwm_aq_rst_sync.sv
module pwm_aq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_aq_cmp_reg.sv
module pwm_aq_cmp_reg
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             shadow_en,
  input  logic [1:0]       load_sel,
  input  logic             cnt_zero,
  input  logic             cnt_prd,
  output logic [CNT_W-1:0] cmp_active
);

  ld_sel_e          sel;
  logic             moment_hit;
  logic             load_hit;
  logic             sh_en;
  logic             act_en;
  logic [CNT_W-1:0] sh_q;
  logic [CNT_W-1:0] sh_nxt;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] act_nxt;

  assign sel = ld_sel_e'(load_sel);

  always_comb begin
    case (sel)
      LD_ZERO:   moment_hit = cnt_zero;
      LD_PRD:    moment_hit = cnt_prd;
      LD_EITHER: moment_hit = cnt_zero | cnt_prd;
      default:   moment_hit = 1'b0;
    endcase
  end

  // staged copy follows every write; active copy takes write or staged data
  always_comb begin
    load_hit = shadow_en & moment_hit;
    sh_en    = wr_en;
    sh_nxt   = wr_data;
    act_en   = (wr_en & ~shadow_en) | load_hit;
    act_nxt  = shadow_en ? sh_q : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_nxt;
    end
  end

  assign cmp_active = act_q;

endmodule

// File: rtl/pwm_aq_event_det.sv
module pwm_aq_event_det
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           cnt_zero,
  input  logic                           cnt_up,
  input  logic [CNT_W-1:0]               cnt_val,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_act,
  output ev_vec_t                        ev
);

  logic [NUM_CMP-1:0] match;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_match
    assign match[g] = cnt_up & (cnt_val == cmp_act[g]);
  end

  assign ev = {match, cnt_zero};

endmodule

// File: rtl/pwm_aq_out_chan.sv
module pwm_aq_out_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ev_vec_t          ev,
  input  logic [ACT_W-1:0] act_cfg,
  input  logic [1:0]       force_sel,
  output logic             pwm
);

  localparam logic [ACT_W-1:0] USED_MASK = used_act_mask();

  aq_act_e codes [NUM_EV];
  aq_act_e win_code;
  logic    win_hit;
  frc_e    frc;
  logic    frc_on;
  logic    frc_lvl;
  logic    upd_en;
  logic    pwm_q;
  logic    pwm_nxt;
  logic    unused_rsvd_bits;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_field
    assign codes[g] = aq_act_e'(act_cfg[g*FIELD_STRIDE +: 2]);
  end

  assign unused_rsvd_bits = ^(act_cfg & ~USED_MASK);

  // ascending scan: a higher-ranked event with a nonzero code wins
  always_comb begin
    win_code = ACT_NONE;
    win_hit  = 1'b0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (ev[i] && (codes[i] != ACT_NONE)) begin
        win_code = codes[i];
        win_hit  = 1'b1;
      end
    end
  end

  always_comb begin
    frc = frc_e'(force_sel);
    case (frc)
      FRC_LOW:  begin frc_on = 1'b1; frc_lvl = 1'b0; end
      FRC_HIGH: begin frc_on = 1'b1; frc_lvl = 1'b1; end
      default:  begin frc_on = 1'b0; frc_lvl = 1'b0; end
    endcase
  end

  always_comb begin
    upd_en  = win_hit | frc_on;
    pwm_nxt = frc_on ? frc_lvl : apply_action(win_code, pwm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (upd_en) begin
      pwm_q <= pwm_nxt;
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/pwm_aq_stage.sv
module pwm_aq_stage
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_zero,
  input  logic             cnt_prd,
  input  logic             cnt_up,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic             cmpa_shadow_en,
  input  logic [1:0]       cmpa_load_sel,
  input  logic             cmpb_shadow_en,
  input  logic [1:0]       cmpb_load_sel,
  input  logic [ACT_W-1:0] act_a_cfg,
  input  logic [ACT_W-1:0] act_b_cfg,
  input  logic [FRC_W-1:0] force_cfg,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] cmpa_active,
  output logic [CNT_W-1:0] cmpb_active
);

  logic                          rst_sync_n;
  logic [NUM_CMP-1:0]            wr_v;
  logic [NUM_CMP-1:0][CNT_W-1:0] wdata_v;
  logic [NUM_CMP-1:0]            shadow_v;
  logic [NUM_CMP-1:0][1:0]       ldsel_v;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_act_v;
  logic [NUM_CMP-1:0][ACT_W-1:0] act_v;
  logic [NUM_CMP-1:0]            pwm_v;
  ev_vec_t                       ev;

  assign wr_v     = {cmpb_wr, cmpa_wr};
  assign wdata_v  = {cmpb_wdata, cmpa_wdata};
  assign shadow_v = {cmpb_shadow_en, cmpa_shadow_en};
  assign ldsel_v  = {cmpb_load_sel, cmpa_load_sel};
  assign act_v    = {act_b_cfg, act_a_cfg};

  pwm_aq_rst_sync #(.STAGES(SYNC_STG)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_ch
    pwm_aq_cmp_reg #(.CNT_W(CNT_W)) i_cmp (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en      (wr_v[g]),
      .wr_data    (wdata_v[g]),
      .shadow_en  (shadow_v[g]),
      .load_sel   (ldsel_v[g]),
      .cnt_zero   (cnt_zero),
      .cnt_prd    (cnt_prd),
      .cmp_active (cmp_act_v[g])
    );

    pwm_aq_out_chan i_out (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ev        (ev),
      .act_cfg   (act_v[g]),
      .force_sel (force_cfg[2*g +: 2]),
      .pwm       (pwm_v[g])
    );
  end

  pwm_aq_event_det #(.CNT_W(CNT_W)) i_evt (
    .cnt_zero (cnt_zero),
    .cnt_up   (cnt_up),
    .cnt_val  (cnt_val),
    .cmp_act  (cmp_act_v),
    .ev       (ev)
  );

  assign pwm_a       = pwm_v[0];
  assign pwm_b       = pwm_v[1];
  assign cmpa_active = cmp_act_v[0];
  assign cmpb_active = cmp_act_v[1];

endmodule

// File: rtl/pwm_aq_stage_chk.sv
module pwm_aq_stage_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_zero,
  input logic             cnt_prd,
  input logic             cnt_up,
  input logic             cmpa_wr,
  input logic [CNT_W-1:0] cmpa_wdata,
  input logic             cmpa_shadow_en,
  input logic             cmpb_shadow_en,
  input logic [1:0]       cmpb_load_sel,
  input logic [3:0]       force_cfg,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [CNT_W-1:0] cmpa_active,
  input logic [CNT_W-1:0] cmpb_active
);

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!pwm_a && !pwm_b && cmpa_active == '0 && cmpb_active == '0));

  assert_imm_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cmpa_wr) && !$past(cmpa_shadow_en))
      |-> (cmpa_active == $past(cmpa_wdata)));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cmpa_shadow_en) && !$past(cnt_zero) && !$past(cnt_prd))
      |-> $stable(cmpa_active));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(cmpb_shadow_en) && ($past(cmpb_load_sel) == 2'd3))
      |-> $stable(cmpb_active));

  assert_hold_no_event_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(cnt_zero)
      && !($past(cnt_up) && ($past(cnt_val) == $past(cmpa_active)))
      && !($past(cnt_up) && ($past(cnt_val) == $past(cmpb_active)))
      && (($past(force_cfg[1:0]) == 2'd0) || ($past(force_cfg[1:0]) == 2'd3)))
      |-> $stable(pwm_a));

  assert_force_low_a_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && ($past(force_cfg[1:0]) == 2'd1)) |-> !pwm_a);

  assert_force_high_b_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && ($past(force_cfg[3:2]) == 2'd2)) |-> pwm_b);

endmodule

bind pwm_aq_stage pwm_aq_stage_chk #(.CNT_W(CNT_W)) i_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .cnt_val        (cnt_val),
  .cnt_zero       (cnt_zero),
  .cnt_prd        (cnt_prd),
  .cnt_up         (cnt_up),
  .cmpa_wr        (cmpa_wr),
  .cmpa_wdata     (cmpa_wdata),
  .cmpa_shadow_en (cmpa_shadow_en),
  .cmpb_shadow_en (cmpb_shadow_en),
  .cmpb_load_sel  (cmpb_load_sel),
  .force_cfg      (force_cfg),
  .pwm_a          (pwm_a),
  .pwm_b          (pwm_b),
  .cmpa_active    (cmpa_active),
  .cmpb_active    (cmpb_active)
);

// File: tb/test_pwm_aq_stage.sv
module test_pwm_aq_stage;

  localparam int CNT_W    = 16;
  localparam int PRD      = 9;
  localparam int NVEC     = 7;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic        inv;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [7:0]  exp_a;
    logic [7:0]  exp_b;
  } vec_t;

  // R9 / R10 vectors: counter 0..9, expected high ticks per 10-tick period
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'd0,  16'd4,  8'd0,  8'd4},
    '{1'b0, 16'd1,  16'd9,  8'd1,  8'd9},
    '{1'b0, 16'd4,  16'd12, 8'd4,  8'd10},
    '{1'b0, 16'd9,  16'd0,  8'd9,  8'd0},
    '{1'b1, 16'd3,  16'd6,  8'd7,  8'd6},
    '{1'b1, 16'd0,  16'd1,  8'd10, 8'd1},
    '{1'b1, 16'd12, 16'd2,  8'd0,  8'd2}
  };

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero, cnt_prd, cnt_up;
  logic             cmpa_wr, cmpb_wr;
  logic [CNT_W-1:0] cmpa_wdata, cmpb_wdata;
  logic             cmpa_shadow_en, cmpb_shadow_en;
  logic [1:0]       cmpa_load_sel, cmpb_load_sel;
  logic [11:0]      act_a_cfg, act_b_cfg;
  logic [3:0]       force_cfg;
  logic             pwm_a, pwm_b;
  logic [CNT_W-1:0] cmpa_active, cmpb_active;

  int errors = 0;
  int checks = 0;
  int wd_cnt = 0;

  pwm_aq_stage #(.CNT_W(CNT_W)) i_pwm_aq_stage (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_zero(cnt_zero),
    .cnt_prd(cnt_prd), .cnt_up(cnt_up), .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
    .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata), .cmpa_shadow_en(cmpa_shadow_en),
    .cmpa_load_sel(cmpa_load_sel), .cmpb_shadow_en(cmpb_shadow_en),
    .cmpb_load_sel(cmpb_load_sel), .act_a_cfg(act_a_cfg), .act_b_cfg(act_b_cfg),
    .force_cfg(force_cfg), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cmpa_active(cmpa_active), .cmpb_active(cmpb_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt == WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", wd_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic write_a(input logic [15:0] v);
    cmpa_wr = 1'b1; cmpa_wdata = v; cyc(); cmpa_wr = 1'b0;
  endtask

  task automatic write_b(input logic [15:0] v);
    cmpb_wr = 1'b1; cmpb_wdata = v; cyc(); cmpb_wr = 1'b0;
  endtask

  task automatic pulse(input logic z, input logic p);
    cnt_zero = z; cnt_prd = p; cyc(); cnt_zero = 1'b0; cnt_prd = 1'b0;
  endtask

  task automatic run_count(input int n, output int ha, output int hb);
    int cv;
    cv = 0; ha = 0; hb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      cnt_val  = CNT_W'(cv);
      cnt_zero = (cv == 0);
      cnt_prd  = (cv == PRD);
      cv = (cv == PRD) ? 0 : cv + 1;
    end
  endtask

  initial begin
    int ha, hb;
    rst_n = 1'b1;
    cnt_val = '0; cnt_zero = 0; cnt_prd = 0; cnt_up = 0;
    cmpa_wr = 0; cmpb_wr = 0; cmpa_wdata = '0; cmpb_wdata = '0;
    cmpa_shadow_en = 0; cmpb_shadow_en = 0; cmpa_load_sel = 0; cmpb_load_sel = 0;
    act_a_cfg = '0; act_b_cfg = '0; force_cfg = '0;
    #1 rst_n = 1'b0;
    cyc(); cyc();
    check("R1 pwm_a in reset", 32'(pwm_a), 0);
    check("R1 pwm_b in reset", 32'(pwm_b), 0);
    check("R1 cmpa in reset", 32'(cmpa_active), 0);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R2 immediate write
    write_a(16'h0005);
    check("R2 cmpa immediate", 32'(cmpa_active), 32'h5);
    write_b(16'h00a1);
    check("R2 cmpb immediate", 32'(cmpb_active), 32'ha1);

    // R3 shadow, load on zero
    cmpa_shadow_en = 1'b1; cmpa_load_sel = 2'd0;
    write_a(16'h1234);
    check("R3 shadow write holds", 32'(cmpa_active), 32'h5);
    pulse(0, 1);
    check("R3 sel0 ignores period", 32'(cmpa_active), 32'h5);
    pulse(1, 0);
    check("R3 sel0 loads on zero", 32'(cmpa_active), 32'h1234);
    // load on period
    cmpa_load_sel = 2'd1;
    write_a(16'h0042);
    pulse(1, 0);
    check("R3 sel1 ignores zero", 32'(cmpa_active), 32'h1234);
    pulse(0, 1);
    check("R3 sel1 loads on period", 32'(cmpa_active), 32'h42);
    // either
    cmpa_load_sel = 2'd2;
    write_a(16'h0077);
    pulse(0, 1);
    check("R3 sel2 loads on period", 32'(cmpa_active), 32'h77);
    write_a(16'h0078);
    pulse(1, 0);
    check("R3 sel2 loads on zero", 32'(cmpa_active), 32'h78);

    // R4 freeze
    cmpb_shadow_en = 1'b1; cmpb_load_sel = 2'd3;
    write_b(16'h0099);
    pulse(1, 0);
    pulse(0, 1);
    pulse(1, 1);
    check("R4 freeze never loads", 32'(cmpb_active), 32'ha1);
    cmpa_shadow_en = 1'b0; cmpb_shadow_en = 1'b0;

    // R5 direction and field mapping
    write_a(16'h0020);
    write_b(16'h0030);
    act_a_cfg = 12'h020; act_b_cfg = 12'h200;
    force_cfg = 4'b0101; cyc();
    check("R8 force low A", 32'(pwm_a), 0);
    check("R8 force low B", 32'(pwm_b), 0);
    force_cfg = 4'b0000;
    cnt_val = 16'h0020; cnt_up = 1'b0; cyc();
    check("R5 no event counting down", 32'(pwm_a), 0);
    cnt_up = 1'b1; cyc();
    check("R5 cmpA up sets A", 32'(pwm_a), 1);
    check("R5 cmpA ignored by B field", 32'(pwm_b), 0);
    cnt_val = 16'h0030; cyc();
    check("R5 cmpB up sets B", 32'(pwm_b), 1);
    cnt_val = 16'h0021; cyc(); cyc();
    check("R6 hold without event", 32'(pwm_a), 1);
    cnt_up = 1'b0; cnt_val = '0;

    // R6 codes
    act_a_cfg = 12'h003;
    pulse(1, 0);
    check("R6 toggle to low", 32'(pwm_a), 0);
    pulse(1, 0);
    check("R6 toggle to high", 32'(pwm_a), 1);
    act_a_cfg = 12'h001;
    pulse(1, 0);
    check("R6 code low", 32'(pwm_a), 0);
    act_a_cfg = 12'h002;
    pulse(1, 0);
    check("R6 code high", 32'(pwm_a), 1);

    // R7 priority
    write_a(16'h0010);
    write_b(16'h0010);
    act_a_cfg = 12'h212;
    force_cfg = 4'b0001; cyc(); force_cfg = '0;
    cnt_val = 16'h0010; cnt_up = 1'b1; pulse(1, 0);
    check("R7 cmpB beats cmpA and zero", 32'(pwm_a), 1);
    act_a_cfg = 12'h012;
    force_cfg = 4'b0010; cyc(); force_cfg = '0;
    pulse(1, 0);
    check("R7 cmpA beats zero", 32'(pwm_a), 0);
    act_a_cfg = 12'h002;
    pulse(1, 0);
    check("R7 none code lets zero act", 32'(pwm_a), 1);
    cnt_up = 1'b0; cnt_val = '0;

    // R8 force override
    act_b_cfg = 12'h001;
    force_cfg = 4'b1001;
    pulse(1, 0);
    check("R8 A held low against action", 32'(pwm_a), 0);
    check("R8 B held high against action", 32'(pwm_b), 1);
    pulse(1, 0);
    check("R8 A still low", 32'(pwm_a), 0);
    check("R8 B still high", 32'(pwm_b), 1);
    force_cfg = 4'b1111;
    pulse(1, 0);
    check("R8 code3 no force A", 32'(pwm_a), 1);
    check("R8 code3 no force B", 32'(pwm_b), 0);
    force_cfg = '0;

    // R9 / R10 duty table
    cnt_up = 1'b1;
    act_b_cfg = 12'h102;
    for (int v = 0; v < NVEC; v++) begin
      act_a_cfg = VECS[v].inv ? 12'h021 : 12'h012;
      write_a(VECS[v].ca);
      write_b(VECS[v].cb);
      run_count(2 * (PRD + 1), ha, hb);
      run_count(PRD + 1, ha, hb);
      check(VECS[v].inv ? "R10 inverted high ticks A" : "R9 high ticks A",
            32'(ha), 32'(VECS[v].exp_a));
      check("R9 high ticks B", 32'(hb), 32'(VECS[v].exp_b));
    end
    cnt_zero = 0; cnt_prd = 0;

    // R1 asynchronous reset mid-run
    force_cfg = 4'b1010; cyc();
    rst_n = 1'b0; #1;
    check("R1 async reset A", 32'(pwm_a), 0);
    check("R1 async reset B", 32'(pwm_b), 0);
    check("R1 async reset cmpa", 32'(cmpa_active), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule